// File: doc/BRIEF.md
# Asynchronous Input Qualifier

This block conditions processor control inputs that can arrive with no fixed relation to the core clock. Every such pin is active-low. Each pin passes through a two-stage synchronizer and is then qualified according to its kind. Level-kind requests (address-bit-20 masking, numeric-error ignore, maskable interrupt, stop-clock) produce a qualified level. That level rises only after the synchronized request has been seen asserted on two consecutive clocks, and it falls on the first negated sample.

Edge-kind requests (non-maskable interrupt, init, system-management interrupt, cache flush) produce a one-clock event pulse. The pulse appears only when the synchronized pin was negated for at least two clocks, was then asserted for at least two clocks, and has not already produced a pulse during the same assertion.

A third path carries the write-buffer-empty acknowledge. This pin is of the synchronous kind, so it is registered directly on the clock edge with no width filtering. A configuration bit can force the acknowledge to read as asserted whatever the pin does. Downstream logic uses the qualified levels and pulses in place of the raw pins.

Top module: `async_in_qual`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises, every bit of lvl_req_o and evt_pulse_o is 0 and wbe_ack_o is 0.
- R2: Pins are active-low (0 = asserted). A level pin first driven low just before rising edge k leaves lvl_req_o low through edge k+2 and drives it high after edge k+3, so the synchronizer adds two clocks.
- R3: A lvl_req_o bit rises only after two consecutive asserted synchronized samples. A level pin asserted for one clock never raises it. A pin asserted for exactly two clocks raises it for exactly one clock.
- R4: A lvl_req_o bit falls on the first negated synchronized sample. When its pin is released just before edge m, the bit is still high after edge m+1 and is low after edge m+2.
- R5: When an edge pin has been negated for at least two clocks and is asserted just before edge k, evt_pulse_o for that pin is high only after edge k+3 and for that single clock.
- R6: An edge pin asserted for fewer than two clocks raises no event. One asserted for exactly two clocks, after enough negated time, raises exactly one event.
- R7: Once an event has fired, no further event is raised until the pin has been negated for at least two clocks. Holding the pin asserted gives one pulse. A one-clock negation between two assertions gives no second pulse, and a two-clock negation does.
- R8: The edge-path synchronizers reset to the asserted state and the negated-time count resets to zero. An edge pin held asserted through reset therefore raises no event until it has been negated for two clocks and asserted again.
- R9: wbe_ack_o is registered once from the pin, with no pulse-width filtering. When wbe_ignore is 1 at an edge, wbe_ack_o is 1 after that edge. When wbe_ignore is 0, wbe_ack_o after the edge equals the inverse of wbe_ack_n sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_pin_n | input | N_LVL | Raw active-low level-kind request pins |
| edge_pin_n | input | N_EDGE | Raw active-low edge-kind request pins |
| wbe_ack_n | input | 1 | Raw active-low write-buffer-empty acknowledge |
| wbe_ignore | input | 1 | When 1, forces the acknowledge to read as asserted |
| lvl_req_o | output | N_LVL | Qualified active-high levels |
| evt_pulse_o | output | N_EDGE | One-clock active-high event pulses |
| wbe_ack_o | output | 1 | Registered, gated active-high acknowledge |

## Verification
The hardest case to reach from the ports is an edge pin whose assertions and negations fall just around the two-clock limits. This includes a one-clock dip inside a long assertion, a two-clock negation that must re-arm the channel, and a pin held asserted across a reset. Directed sequences build each of these on purpose and count the pulses in a window that covers the four-clock latency. A long run then toggles every pin with a high per-clock probability, which produces many one-clock and two-clock runs. A behavioural reference that tracks run lengths is compared with the outputs on every clock.

// File: rtl/aiq_pkg.sv
package aiq_pkg;

    // Phase of one edge-kind qualification channel
    typedef enum logic [1:0] {
        EQ_WAIT_LOW = 2'd0,   // collecting negated samples
        EQ_ARMED    = 2'd1,   // enough negated time seen
        EQ_HIGH     = 2'd2,   // collecting asserted samples while armed
        EQ_SPENT    = 2'd3    // event raised, waiting for negation
    } eq_phase_e;

    // Width needed to hold a count up to max_val (at least 1 bit)
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/aiq_sync.sv
// Multi-bit synchronizer: inverts active-low pins, then STAGES flops.
module aiq_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = ~pin_n;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= {(STAGES*W){RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.pipe[STAGES-1];

endmodule

// File: rtl/aiq_lvl_qual.sv
// Level qualification: output rises after HOLD consecutive asserted
// samples and falls on the first negated one.
module aiq_lvl_qual #(
    parameter int unsigned W    = 4,
    parameter int unsigned HOLD = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] lvl_o
);

    localparam int unsigned    CW     = aiq_pkg::cnt_width(HOLD);
    localparam logic [CW-1:0]  HOLD_C = CW'(HOLD);
    localparam logic [CW-1:0]  ONE_C  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          lvl;
    } lq_ch_t;

    lq_ch_t [W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            if (!sync_i[i]) begin
                st_d[i].run = '0;
                st_d[i].lvl = 1'b0;
            end else begin
                if (st_q[i].run != HOLD_C) begin
                    st_d[i].run = st_q[i].run + ONE_C;
                end
                st_d[i].lvl = (st_d[i].run >= HOLD_C);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            lvl_o[i] = st_q[i].lvl;
        end
    end

endmodule

// File: rtl/aiq_edge_qual.sv
// One edge-kind channel: LOW negated samples arm it, HIGH asserted
// samples while armed raise a single one-clock event.
module aiq_edge_qual #(
    parameter int unsigned LOW  = 2,
    parameter int unsigned HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic evt_o
);

    import aiq_pkg::*;

    localparam int unsigned   MAXC   = (LOW > HIGH) ? LOW : HIGH;
    localparam int unsigned   CW     = cnt_width(MAXC);
    localparam logic [CW-1:0] LOW_C  = CW'(LOW);
    localparam logic [CW-1:0] HIGH_C = CW'(HIGH);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    typedef struct packed {
        eq_phase_e     phase;
        logic [CW-1:0] run;
        logic          evt;
    } eq_st_t;

    eq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        case (st_q.phase)
            EQ_WAIT_LOW: begin
                if (sync_i) begin
                    st_d.run = '0;
                end else begin
                    if (st_q.run != LOW_C) begin
                        st_d.run = st_q.run + ONE_C;
                    end
                    if (st_d.run >= LOW_C) begin
                        st_d.phase = EQ_ARMED;
                    end
                end
            end
            EQ_ARMED: begin
                if (sync_i) begin
                    if (HIGH <= 1) begin
                        st_d.evt   = 1'b1;
                        st_d.phase = EQ_SPENT;
                        st_d.run   = '0;
                    end else begin
                        st_d.run   = ONE_C;
                        st_d.phase = EQ_HIGH;
                    end
                end
            end
            EQ_HIGH: begin
                if (!sync_i) begin
                    st_d.run   = ONE_C;
                    st_d.phase = (LOW <= 1) ? EQ_ARMED : EQ_WAIT_LOW;
                end else begin
                    if (st_q.run != HIGH_C) begin
                        st_d.run = st_q.run + ONE_C;
                    end
                    if (st_d.run >= HIGH_C) begin
                        st_d.evt   = 1'b1;
                        st_d.phase = EQ_SPENT;
                        st_d.run   = '0;
                    end
                end
            end
            EQ_SPENT: begin
                if (!sync_i) begin
                    st_d.run   = ONE_C;
                    st_d.phase = (LOW <= 1) ? EQ_ARMED : EQ_WAIT_LOW;
                end
            end
            default: begin
                st_d.phase = EQ_WAIT_LOW;
                st_d.run   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= EQ_WAIT_LOW;
            st_q.run   <= '0;
            st_q.evt   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

endmodule

// File: rtl/aiq_ack_gate.sv
// Synchronous-kind acknowledge: registered once, optionally forced on.
module aiq_ack_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    input  logic ignore_i,
    output logic ack_o
);

    typedef struct packed {
        logic ack;
    } ag_st_t;

    ag_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = ignore_i | ~ack_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o = st_q.ack;

endmodule

// File: rtl/async_in_qual.sv
module async_in_qual #(
    parameter int unsigned N_LVL       = 4,
    parameter int unsigned N_EDGE      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LVL_HOLD    = 2,
    parameter int unsigned EDGE_LOW    = 2,
    parameter int unsigned EDGE_HIGH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  lvl_pin_n,
    input  logic [N_EDGE-1:0] edge_pin_n,
    input  logic              wbe_ack_n,
    input  logic              wbe_ignore,
    output logic [N_LVL-1:0]  lvl_req_o,
    output logic [N_EDGE-1:0] evt_pulse_o,
    output logic              wbe_ack_o
);

    logic [N_LVL-1:0]  lvl_sync;
    logic [N_EDGE-1:0] edge_sync;

    // Level path: synchronizer starts negated
    aiq_sync #(
        .W       (N_LVL),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_lvl_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (lvl_pin_n),
        .sync_o (lvl_sync)
    );

    aiq_lvl_qual #(
        .W    (N_LVL),
        .HOLD (LVL_HOLD)
    ) u_lvl_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (lvl_sync),
        .lvl_o  (lvl_req_o)
    );

    // Edge path: synchronizer starts asserted so reset never arms a channel
    aiq_sync #(
        .W       (N_EDGE),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_edge_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (edge_pin_n),
        .sync_o (edge_sync)
    );

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        aiq_edge_qual #(
            .LOW  (EDGE_LOW),
            .HIGH (EDGE_HIGH)
        ) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (edge_sync[g]),
            .evt_o  (evt_pulse_o[g])
        );
    end

    aiq_ack_gate u_ack_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n_i  (wbe_ack_n),
        .ignore_i (wbe_ignore),
        .ack_o    (wbe_ack_o)
    );

endmodule

// File: rtl/aiq_checker.sv
module aiq_checker #(
    parameter int unsigned N_LVL       = 4,
    parameter int unsigned N_EDGE      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LVL_HOLD    = 2,
    parameter int unsigned EDGE_LOW    = 2,
    parameter int unsigned EDGE_HIGH   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_LVL-1:0]  lvl_pin_n,
    input logic [N_EDGE-1:0] edge_pin_n,
    input logic              wbe_ack_n,
    input logic              wbe_ignore,
    input logic [N_LVL-1:0]  lvl_req_o,
    input logic [N_EDGE-1:0] evt_pulse_o,
    input logic              wbe_ack_o
);

    // Events never last two clocks in a row
    p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse_o & $past(evt_pulse_o)) == '0);

    // Forced acknowledge
    p_ack_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wbe_ignore |=> wbe_ack_o);

    // Unforced acknowledge follows the pin one clock later
    p_ack_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wbe_ignore |=> (wbe_ack_o == !$past(wbe_ack_n)));

    // Pin-history checks written for the default timing
    if (SYNC_STAGES == 2 && LVL_HOLD == 2 && EDGE_LOW == 2 && EDGE_HIGH == 2) begin : g_dflt
        // A rising level needs the pin asserted 3 and 4 clocks back
        p_lvl_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((lvl_req_o & ~$past(lvl_req_o))
             & ($past(lvl_pin_n, 3) | $past(lvl_pin_n, 4))) == '0);

        // A negated pin 3 clocks back forces the level low
        p_lvl_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_req_o & $past(lvl_pin_n, 3)) == '0);

        // An event needs two negated then two asserted pin samples
        p_evt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_pulse_o & ~($past(edge_pin_n, 6) & $past(edge_pin_n, 5)
                            & ~$past(edge_pin_n, 4) & ~$past(edge_pin_n, 3))) == '0);
    end

endmodule

bind async_in_qual aiq_checker #(
    .N_LVL       (N_LVL),
    .N_EDGE      (N_EDGE),
    .SYNC_STAGES (SYNC_STAGES),
    .LVL_HOLD    (LVL_HOLD),
    .EDGE_LOW    (EDGE_LOW),
    .EDGE_HIGH   (EDGE_HIGH)
) u_chk (.*);

// File: tb/tb_async_in_qual.sv
`timescale 1ns/1ps
module tb_async_in_qual;

    localparam int NL = 4;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lvl_pin_n = '1;
    logic [NE-1:0] edge_pin_n = '1;
    logic          wbe_ack_n = 1'b1;
    logic          wbe_ignore = 1'b0;
    logic [NL-1:0] lvl_req_o;
    logic [NE-1:0] evt_pulse_o;
    logic          wbe_ack_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    async_in_qual dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_pin_n   (lvl_pin_n),
        .edge_pin_n  (edge_pin_n),
        .wbe_ack_n   (wbe_ack_n),
        .wbe_ignore  (wbe_ignore),
        .lvl_req_o   (lvl_req_o),
        .evt_pulse_o (evt_pulse_o),
        .wbe_ack_o   (wbe_ack_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [NL-1:0] lq[$];
    logic [NE-1:0] eq[$];
    int  lrun  [NL];
    int  elow  [NE];
    int  ehigh [NE];
    bit  earm  [NE];
    logic [NL-1:0] x_lvl = '0;
    logic [NE-1:0] x_evt = '0;
    logic          x_ack = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            lq.delete(); lq.push_back('0); lq.push_back('0);
            eq.delete(); eq.push_back('1); eq.push_back('1);
            for (int i = 0; i < NL; i++) lrun[i] = 0;
            for (int i = 0; i < NE; i++) begin
                elow[i] = 0; ehigh[i] = 0; earm[i] = 1'b0;
            end
            x_lvl = '0; x_evt = '0; x_ack = 1'b0;
        end else begin
            logic [NL-1:0] lv;
            logic [NE-1:0] ev;
            lv = lq.pop_front(); lq.push_back(~lvl_pin_n);
            ev = eq.pop_front(); eq.push_back(~edge_pin_n);
            for (int i = 0; i < NL; i++) begin
                lrun[i] = lv[i] ? lrun[i] + 1 : 0;
                x_lvl[i] = (lrun[i] >= 2);
            end
            for (int i = 0; i < NE; i++) begin
                x_evt[i] = 1'b0;
                if (ev[i]) begin
                    if (ehigh[i] == 0) earm[i] = (elow[i] >= 2);
                    elow[i] = 0;
                    ehigh[i]++;
                    if (earm[i] && ehigh[i] == 2) x_evt[i] = 1'b1;
                end else begin
                    ehigh[i] = 0;
                    elow[i]++;
                end
            end
            x_ack = wbe_ignore | ~wbe_ack_n;
        end
    end

    // Per-clock comparison
    always @(negedge clk) begin
        if (!done && $time > 15) begin
            check("R2/R3/R4 level vs model", 32'(lvl_req_o), 32'(x_lvl));
            check("R5/R6/R7/R8 event vs model", 32'(evt_pulse_o), 32'(x_evt));
            check("R9 ack vs model", 32'(wbe_ack_o), 32'(x_ack));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic count_evt(input int ch, input int n, inout int acc);
        for (int k = 0; k < n; k++) begin
            tick(1);
            acc += int'(evt_pulse_o[ch]);
        end
    endtask

    task automatic count_lvl(input int ch, input int n, inout int acc);
        for (int k = 0; k < n; k++) begin
            tick(1);
            acc += int'(lvl_req_o[ch]);
        end
    endtask

    // ---------------- directed + random sequence ----------------
    initial begin
        int acc;
        tick(3);
        check("R1 lvl in reset", 32'(lvl_req_o), 0);
        check("R1 evt in reset", 32'(evt_pulse_o), 0);
        check("R1 ack in reset", 32'(wbe_ack_o), 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 lvl after release", 32'(lvl_req_o), 0);
        check("R1 evt after release", 32'(evt_pulse_o), 0);
        check("R1 ack after release", 32'(wbe_ack_o), 0);
        tick(6);

        // R2 latency, R4 drop
        lvl_pin_n[0] = 1'b0;
        tick(3); check("R2 level not yet up", 32'(lvl_req_o[0]), 0);
        tick(1); check("R2 level up on 4th edge", 32'(lvl_req_o[0]), 1);
        tick(3);
        lvl_pin_n[0] = 1'b1;
        tick(2); check("R4 level still up", 32'(lvl_req_o[0]), 1);
        tick(1); check("R4 level dropped", 32'(lvl_req_o[0]), 0);

        // R3 one-clock and two-clock assertions
        lvl_pin_n[1] = 1'b0; tick(1); lvl_pin_n[1] = 1'b1;
        acc = 0; count_lvl(1, 8, acc);
        check("R3 one-clock level ignored", 32'(acc), 0);
        lvl_pin_n[1] = 1'b0; tick(2); lvl_pin_n[1] = 1'b1;
        acc = 0; count_lvl(1, 8, acc);
        check("R3 two-clock level one cycle", 32'(acc), 1);

        // R5 pulse timing, R7 held
        edge_pin_n[0] = 1'b0;
        tick(3); check("R5 no event yet", 32'(evt_pulse_o[0]), 0);
        tick(1); check("R5 event on 4th edge", 32'(evt_pulse_o[0]), 1);
        tick(1); check("R5 event one clock", 32'(evt_pulse_o[0]), 0);
        acc = 0; count_evt(0, 10, acc);
        check("R7 held pin no repeat", 32'(acc), 0);
        edge_pin_n[0] = 1'b1;
        tick(5);

        // R6 short assertion and exact two clocks
        edge_pin_n[1] = 1'b0; tick(1); edge_pin_n[1] = 1'b1;
        acc = 0; count_evt(1, 8, acc);
        check("R6 one-clock edge ignored", 32'(acc), 0);
        edge_pin_n[1] = 1'b0; tick(2); edge_pin_n[1] = 1'b1;
        acc = 0; count_evt(1, 8, acc);
        check("R6 two-clock edge one event", 32'(acc), 1);

        // R7 short and sufficient negation gaps
        edge_pin_n[2] = 1'b0; tick(6);
        edge_pin_n[2] = 1'b1; tick(1);
        edge_pin_n[2] = 1'b0;
        acc = 0; count_evt(2, 8, acc);
        check("R7 one-clock gap no event", 32'(acc), 0);
        edge_pin_n[2] = 1'b1; tick(2);
        edge_pin_n[2] = 1'b0;
        acc = 0; count_evt(2, 8, acc);
        check("R7 two-clock gap one event", 32'(acc), 1);
        edge_pin_n[2] = 1'b1; tick(4);

        // R8 pin asserted through reset
        edge_pin_n[3] = 1'b0;
        rst_n = 1'b0; tick(3); rst_n = 1'b1;
        acc = 0; count_evt(3, 10, acc);
        check("R8 no event after reset", 32'(acc), 0);
        edge_pin_n[3] = 1'b1;
        acc = 0; count_evt(3, 3, acc);
        edge_pin_n[3] = 1'b0;
        count_evt(3, 8, acc);
        check("R8 event after re-arm", 32'(acc), 1);
        edge_pin_n[3] = 1'b1; tick(4);

        // R9 acknowledge gate
        wbe_ignore = 1'b1; wbe_ack_n = 1'b1;
        tick(1); check("R9 forced ack", 32'(wbe_ack_o), 1);
        wbe_ignore = 1'b0;
        tick(1); check("R9 ack follows negated pin", 32'(wbe_ack_o), 0);
        wbe_ack_n = 1'b0;
        tick(1); check("R9 single-clock ack passes", 32'(wbe_ack_o), 1);
        wbe_ack_n = 1'b1;
        tick(1); check("R9 ack released", 32'(wbe_ack_o), 0);

        // Random toggling, compared against the model every clock
        for (int c = 0; c < 3000; c++) begin
            tick(1);
            for (int b = 0; b < NL; b++)
                if ($urandom_range(2) == 0) lvl_pin_n[b] = ~lvl_pin_n[b];
            for (int b = 0; b < NE; b++)
                if ($urandom_range(2) == 0) edge_pin_n[b] = ~edge_pin_n[b];
            if ($urandom_range(1) == 0) wbe_ack_n = ~wbe_ack_n;
            if ($urandom_range(15) == 0) wbe_ignore = ~wbe_ignore;
        end
        tick(2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule